// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This controller carries out the complete erase and blank-check procedure for one block of an on-chip flash array, so that software does not have to toggle control lines and time each step itself. A single start pulse, together with a one-hot block choice, launches the run. The controller then drives the write-enable, erase-setup, erase and verify lines of the flash macro. It gates a watchdog enable around the high-voltage phase and separates every step with a wait whose length software chooses.

After each erase pulse the block is read back one 16-bit word at a time. Each read is preceded by a dummy all-ones write to the same word. If any word is not fully erased, the controller repeats the erase pulse, up to a configurable number of attempts. It then closes the sequence and reports success or failure. No pre-programming of the block to zeros is done. A block choice with no bit set, or with several bits set, is refused at once and no flash line moves.

Top module: `fev_seq`

## Requirements
- R1: During and directly after reset, every flash control line, the watchdog enable, the block enables, `busy`, the result pulses and the three status bits are all 0.
- R2: A start with a `blk_sel` that does not have exactly one bit set produces a one-cycle `sel_err` pulse and sets `st_selerr`. No control line is raised, no erase pulse occurs, and the block stays idle.
- R3: Write-enable rises first. Erase-setup and the block enable rise exactly `w_swe_on` cycles later, and erase-setup is never high without write-enable.
- R4: Erase is high only while erase-setup and the watchdog enable are both high. Each erase pulse lasts exactly `w_erase` cycles. The watchdog enable falls together with erase-setup.
- R5: Verify is raised only while write-enable is high and erase-setup is low. Reads then start at the selected block's first word, which is block index times `BLKW`. Each read comes after a dummy write of 16'hFFFF to the same word, and the address steps by one per word.
- R6: A block passes only if every word up to and including its last word reads 16'hFFFF. A mismatching word ends that verify pass at once, and this holds also when the mismatch is the last word.
- R7: After a failed verify a new erase pulse follows, up to `try_limit` pulses in total (a limit of 0 acts as 1). The run then ends in failure.
- R8: The outcome is a one-cycle `done` or `fail` pulse, given only after write-enable has been cleared. The matching sticky bit `st_done` or `st_fail` holds until the next start.
- R9: A start arriving while `busy` is high is ignored. Each accepted start yields exactly one result.
- R10: Only the selected block's enable line is ever raised (at most one at a time), and no other block's contents change.
- R11: Every wait lasts max(value, 1) cycles, taken from the wait inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, ignored while busy |
| blk_sel | input | NBLK | One-hot block choice |
| w_swe_on | input | CW | Wait after write-enable set |
| w_esu_on | input | CW | Wait after erase-setup set |
| w_erase | input | CW | Erase pulse length |
| w_ers_off | input | CW | Wait after erase cleared |
| w_esu_off | input | CW | Wait after erase-setup cleared |
| w_ev_on | input | CW | Wait after verify set |
| w_read | input | CW | Wait from dummy write to read |
| w_ev_off | input | CW | Wait after verify cleared |
| w_swe_off | input | CW | Wait after write-enable cleared |
| try_limit | input | TW | Maximum erase pulses per run |
| rdata | input | 16 | Read data from the flash macro |
| ctl_swe | output | 1 | Write-enable control |
| ctl_esu | output | 1 | Erase-setup control |
| ctl_ers | output | 1 | Erase control |
| ctl_ev | output | 1 | Erase-verify control |
| wdt_en | output | 1 | Watchdog enable |
| blk_en | output | NBLK | Block enable to the macro |
| addr | output | AW | Word address |
| wr | output | 1 | Dummy write strobe |
| wdata | output | 16 | Dummy write data (all ones) |
| rd | output | 1 | Read strobe, data taken the same cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Success pulse |
| fail | output | 1 | Failure pulse |
| sel_err | output | 1 | Bad block choice pulse |
| st_done | output | 1 | Sticky success |
| st_fail | output | 1 | Sticky failure |
| st_selerr | output | 1 | Sticky bad choice |

## Verification
The mismatch test and the end-of-block test are decided in the same read cycle when the final word of a block is the one that stays programmed. That cycle must take the retry path, not the pass path. The bench provokes this by pinning a word at the last address of the chosen block. It then expects a failure after exactly `try_limit` erase pulses and no success pulse. A second collision happens on the final attempt, where the retry decision and the attempt limit meet in the same cycle. That case is judged by counting erase pulses against limits of 0, 1, 2 and 3.

// File: rtl/fev_pkg.sv
package fev_pkg;

    localparam int DW    = 16;
    localparam int NWAIT = 9;

    // Index of each wait value inside the packed wait vector
    localparam int WI_SWE_ON  = 0;
    localparam int WI_ESU_ON  = 1;
    localparam int WI_ERASE   = 2;
    localparam int WI_ERS_OFF = 3;
    localparam int WI_ESU_OFF = 4;
    localparam int WI_EV_ON   = 5;
    localparam int WI_READ    = 6;
    localparam int WI_EV_OFF  = 7;
    localparam int WI_SWE_OFF = 8;

    // Each phase names the wait that follows a control change
    typedef enum logic [3:0] {
        PH_IDLE,
        PH_SWE,
        PH_ESU,
        PH_ERS,
        PH_ECLR,
        PH_ESUCLR,
        PH_EV,
        PH_DWR,
        PH_EVCLR,
        PH_SWECLR
    } phase_e;

    typedef struct packed {
        logic swe;
        logic esu;
        logic ers;
        logic ev;
        logic wdt;
    } ctl_t;

    localparam ctl_t CTL_OFF = '0;

    function automatic logic word_blank(input logic [DW-1:0] w);
        return &w;
    endfunction

endpackage

// File: rtl/fev_timer.sv
module fev_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [CW-1:0] val,
    output logic          tick
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (ld)
            cnt <= val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign tick = (cnt <= CW'(1));
endmodule

// File: rtl/fev_blkmap.sv
module fev_blkmap #(
    parameter int NBLK = 8,
    parameter int BLKW = 8,
    parameter int AW   = 6
) (
    input  logic [NBLK-1:0] sel,
    output logic [AW-1:0]   base,
    output logic [AW-1:0]   last
);
    logic [AW-1:0] idx;

    always_comb begin
        idx = '0;
        for (int i = 0; i < NBLK; i++)
            if (sel[i]) idx = AW'(i);
        base = idx * AW'(BLKW);
        last = base + AW'(BLKW - 1);
    end
endmodule

// File: rtl/fev_fsm.sv
module fev_fsm
    import fev_pkg::*;
#(
    parameter int NBLK = 8,
    parameter int AW   = 6,
    parameter int CW   = 16,
    parameter int TW   = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [NBLK-1:0]            blk_sel,
    input  logic [NWAIT-1:0][CW-1:0]   waits,
    input  logic [TW-1:0]              try_limit,
    input  logic [DW-1:0]              rdata,
    input  logic                       tick,
    input  logic [AW-1:0]              base,
    input  logic [AW-1:0]              last,
    output logic                       ld,
    output logic [CW-1:0]              ld_val,
    output logic [NBLK-1:0]            sel_q,
    output ctl_t                       ctl,
    output logic [NBLK-1:0]            blk_en,
    output logic [AW-1:0]              addr,
    output logic                       wr,
    output logic                       rd,
    output logic                       busy,
    output logic                       done,
    output logic                       fail,
    output logic                       sel_err,
    output logic                       st_done,
    output logic                       st_fail,
    output logic                       st_selerr
);
    phase_e          ph, ph_n;
    ctl_t            ctl_n;
    logic [NBLK-1:0] sel_n;
    logic [AW-1:0]   addr_n;
    logic [TW-1:0]   tries, tries_n;
    logic            pass, pass_n, blk_on, blk_on_n;
    logic            wr_n, done_n, fail_n, err_n;
    logic            std_n, stf_n, ste_n;

    always_comb begin
        ph_n = ph; ctl_n = ctl; sel_n = sel_q; addr_n = addr;
        tries_n = tries; pass_n = pass; blk_on_n = blk_on;
        wr_n = 1'b0; done_n = 1'b0; fail_n = 1'b0; err_n = 1'b0;
        std_n = st_done; stf_n = st_fail; ste_n = st_selerr;
        ld = 1'b0; ld_val = '0; rd = 1'b0;
        unique case (ph)
            PH_IDLE: if (start) begin
                std_n = 1'b0; stf_n = 1'b0; ste_n = 1'b0;
                if ($countones(blk_sel) == 1) begin
                    ph_n = PH_SWE; ctl_n.swe = 1'b1; sel_n = blk_sel;
                    tries_n = TW'(1); pass_n = 1'b0;
                    ld = 1'b1; ld_val = waits[WI_SWE_ON];
                end else begin
                    err_n = 1'b1; ste_n = 1'b1;
                end
            end
            PH_SWE: if (tick) begin
                ph_n = PH_ESU; blk_on_n = 1'b1; ctl_n.esu = 1'b1; ctl_n.wdt = 1'b1;
                ld = 1'b1; ld_val = waits[WI_ESU_ON];
            end
            PH_ESU: if (tick) begin
                ph_n = PH_ERS; ctl_n.ers = 1'b1;
                ld = 1'b1; ld_val = waits[WI_ERASE];
            end
            PH_ERS: if (tick) begin
                ph_n = PH_ECLR; ctl_n.ers = 1'b0;
                ld = 1'b1; ld_val = waits[WI_ERS_OFF];
            end
            PH_ECLR: if (tick) begin
                ph_n = PH_ESUCLR; ctl_n.esu = 1'b0; ctl_n.wdt = 1'b0;
                ld = 1'b1; ld_val = waits[WI_ESU_OFF];
            end
            PH_ESUCLR: if (tick) begin
                ph_n = PH_EV; ctl_n.ev = 1'b1; addr_n = base;
                ld = 1'b1; ld_val = waits[WI_EV_ON];
            end
            PH_EV: if (tick) begin
                ph_n = PH_DWR; wr_n = 1'b1;
                ld = 1'b1; ld_val = waits[WI_READ];
            end
            PH_DWR: if (tick) begin
                rd = 1'b1;
                if (!word_blank(rdata) || addr == last) begin
                    ph_n = PH_EVCLR; ctl_n.ev = 1'b0; pass_n = word_blank(rdata);
                    ld = 1'b1; ld_val = waits[WI_EV_OFF];
                end else begin
                    addr_n = addr + 1'b1; wr_n = 1'b1;
                    ld = 1'b1; ld_val = waits[WI_READ];
                end
            end
            PH_EVCLR: if (tick) begin
                if (pass || tries >= try_limit) begin
                    ph_n = PH_SWECLR; ctl_n.swe = 1'b0; blk_on_n = 1'b0;
                    ld = 1'b1; ld_val = waits[WI_SWE_OFF];
                end else begin
                    ph_n = PH_ESU; tries_n = tries + 1'b1;
                    ctl_n.esu = 1'b1; ctl_n.wdt = 1'b1;
                    ld = 1'b1; ld_val = waits[WI_ESU_ON];
                end
            end
            PH_SWECLR: if (tick) begin
                ph_n = PH_IDLE; done_n = pass; fail_n = !pass;
                std_n = pass; stf_n = !pass;
            end
            default: ph_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= PH_IDLE; ctl <= CTL_OFF; sel_q <= '0; addr <= '0;
            tries <= '0; pass <= 1'b0; blk_on <= 1'b0;
            wr <= 1'b0; done <= 1'b0; fail <= 1'b0; sel_err <= 1'b0;
            st_done <= 1'b0; st_fail <= 1'b0; st_selerr <= 1'b0;
        end else begin
            ph <= ph_n; ctl <= ctl_n; sel_q <= sel_n; addr <= addr_n;
            tries <= tries_n; pass <= pass_n; blk_on <= blk_on_n;
            wr <= wr_n; done <= done_n; fail <= fail_n; sel_err <= err_n;
            st_done <= std_n; st_fail <= stf_n; st_selerr <= ste_n;
        end
    end

    assign blk_en = blk_on ? sel_q : '0;
    assign busy   = (ph != PH_IDLE);
endmodule

// File: rtl/fev_seq.sv
module fev_seq
    import fev_pkg::*;
#(
    parameter int NBLK = 8,
    parameter int BLKW = 8,
    parameter int CW   = 16,
    parameter int TW   = 8,
    parameter int AW   = $clog2(NBLK * BLKW)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [NBLK-1:0] blk_sel,
    input  logic [CW-1:0]   w_swe_on,
    input  logic [CW-1:0]   w_esu_on,
    input  logic [CW-1:0]   w_erase,
    input  logic [CW-1:0]   w_ers_off,
    input  logic [CW-1:0]   w_esu_off,
    input  logic [CW-1:0]   w_ev_on,
    input  logic [CW-1:0]   w_read,
    input  logic [CW-1:0]   w_ev_off,
    input  logic [CW-1:0]   w_swe_off,
    input  logic [TW-1:0]   try_limit,
    input  logic [15:0]     rdata,
    output logic            ctl_swe,
    output logic            ctl_esu,
    output logic            ctl_ers,
    output logic            ctl_ev,
    output logic            wdt_en,
    output logic [NBLK-1:0] blk_en,
    output logic [AW-1:0]   addr,
    output logic            wr,
    output logic [15:0]     wdata,
    output logic            rd,
    output logic            busy,
    output logic            done,
    output logic            fail,
    output logic            sel_err,
    output logic            st_done,
    output logic            st_fail,
    output logic            st_selerr
);
    logic [NWAIT-1:0][CW-1:0] waits;
    logic                     tick, ld;
    logic [CW-1:0]            ld_val;
    logic [NBLK-1:0]          sel_q;
    logic [AW-1:0]            base, last;
    ctl_t                     ctl;

    always_comb begin
        waits[WI_SWE_ON]  = w_swe_on;
        waits[WI_ESU_ON]  = w_esu_on;
        waits[WI_ERASE]   = w_erase;
        waits[WI_ERS_OFF] = w_ers_off;
        waits[WI_ESU_OFF] = w_esu_off;
        waits[WI_EV_ON]   = w_ev_on;
        waits[WI_READ]    = w_read;
        waits[WI_EV_OFF]  = w_ev_off;
        waits[WI_SWE_OFF] = w_swe_off;
    end

    fev_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst(rst), .ld(ld), .val(ld_val), .tick(tick)
    );

    fev_blkmap #(.NBLK(NBLK), .BLKW(BLKW), .AW(AW)) u_map (
        .sel(sel_q), .base(base), .last(last)
    );

    fev_fsm #(.NBLK(NBLK), .AW(AW), .CW(CW), .TW(TW)) u_fsm (
        .clk(clk), .rst(rst), .start(start), .blk_sel(blk_sel),
        .waits(waits), .try_limit(try_limit), .rdata(rdata),
        .tick(tick), .base(base), .last(last),
        .ld(ld), .ld_val(ld_val), .sel_q(sel_q), .ctl(ctl),
        .blk_en(blk_en), .addr(addr), .wr(wr), .rd(rd), .busy(busy),
        .done(done), .fail(fail), .sel_err(sel_err),
        .st_done(st_done), .st_fail(st_fail), .st_selerr(st_selerr)
    );

    assign ctl_swe = ctl.swe;
    assign ctl_esu = ctl.esu;
    assign ctl_ers = ctl.ers;
    assign ctl_ev  = ctl.ev;
    assign wdt_en  = ctl.wdt;
    assign wdata   = '1;
endmodule

// File: rtl/fev_chk.sv
module fev_chk #(
    parameter int NBLK = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            ctl_swe,
    input logic            ctl_esu,
    input logic            ctl_ers,
    input logic            ctl_ev,
    input logic            wdt_en,
    input logic [NBLK-1:0] blk_en,
    input logic            done,
    input logic            fail,
    input logic            sel_err
);
    // R3
    esu_under_swe_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_esu |-> ctl_swe);

    // R4
    ers_guarded_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_ers |-> (ctl_esu && wdt_en));

    // R4
    wdt_follows_esu_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_esu) |-> !wdt_en);

    // R5
    ev_window_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_ev |-> (ctl_swe && !ctl_esu));

    // R10
    blk_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(blk_en));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    result_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && fail));

    // R8
    result_after_swe_chk: assert property (@(posedge clk) disable iff (rst)
        (done || fail) |-> !ctl_swe);

    // R2
    selerr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        sel_err |-> (!ctl_swe && blk_en == '0));
endmodule

bind fev_seq fev_chk #(.NBLK(NBLK)) u_chk (
    .clk(clk), .rst(rst), .ctl_swe(ctl_swe), .ctl_esu(ctl_esu),
    .ctl_ers(ctl_ers), .ctl_ev(ctl_ev), .wdt_en(wdt_en), .blk_en(blk_en),
    .done(done), .fail(fail), .sel_err(sel_err)
);

// File: tb/sim_fev_seq.sv
module sim_fev_seq;
    localparam int NBLK = 8, BLKW = 8, NW = NBLK * BLKW, CW = 16, TW = 8;
    localparam int W_SWE_ON = 3, W_ESU_ON = 2, W_ERASE = 10, W_ERS_OFF = 2;
    localparam int W_ESU_OFF = 2, W_EV_ON = 3, W_READ = 2, W_EV_OFF = 2, W_SWE_OFF = 3;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [NBLK-1:0] blk_sel = '0;
    logic [TW-1:0]   try_limit = 8'd3;
    logic [15:0]     rdata, wdata;
    logic ctl_swe, ctl_esu, ctl_ers, ctl_ev, wdt_en, wr, rd, busy;
    logic done, fail, sel_err, st_done, st_fail, st_selerr;
    logic [NBLK-1:0] blk_en;
    logic [5:0]      addr;

    always #10 clk = ~clk;

    fev_seq #(.NBLK(NBLK), .BLKW(BLKW), .CW(CW), .TW(TW)) u0 (
        .clk(clk), .rst(rst), .start(start), .blk_sel(blk_sel),
        .w_swe_on(CW'(W_SWE_ON)), .w_esu_on(CW'(W_ESU_ON)), .w_erase(CW'(W_ERASE)),
        .w_ers_off(CW'(W_ERS_OFF)), .w_esu_off(CW'(W_ESU_OFF)), .w_ev_on(CW'(W_EV_ON)),
        .w_read(CW'(W_READ)), .w_ev_off(CW'(W_EV_OFF)), .w_swe_off(CW'(W_SWE_OFF)),
        .try_limit(try_limit), .rdata(rdata),
        .ctl_swe(ctl_swe), .ctl_esu(ctl_esu), .ctl_ers(ctl_ers), .ctl_ev(ctl_ev),
        .wdt_en(wdt_en), .blk_en(blk_en), .addr(addr), .wr(wr), .wdata(wdata),
        .rd(rd), .busy(busy), .done(done), .fail(fail), .sel_err(sel_err),
        .st_done(st_done), .st_fail(st_fail), .st_selerr(st_selerr)
    );

    // Flash array model: a block becomes blank after its erase pulse count is used up
    logic [15:0] mem [NW];
    int  need [NBLK];
    bit  stuck_on = 0;
    int  stuck_a = 0;
    bit  ers_m = 0;

    assign rdata = mem[addr];

    always @(negedge clk) begin
        if (ers_m && !ctl_ers) begin
            for (int b = 0; b < NBLK; b++) begin
                if (blk_en[b]) begin
                    if (need[b] > 1) need[b]--;
                    else begin
                        need[b] = 0;
                        for (int w = 0; w < BLKW; w++)
                            if (!(stuck_on && stuck_a == b * BLKW + w))
                                mem[b * BLKW + w] = 16'hFFFF;
                    end
                end
            end
        end
        ers_m = ctl_ers;
    end

    // Scoreboard
    typedef struct { int kind; int pulses; string tag; } exp_t;
    exp_t q[$];
    int n_chk = 0, n_fail = 0, n_res = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor
    int cyc = 0, pulses = 0, ew = 0, mark = 0, exp_a = 0, cur_base = 0;
    bit pend = 0, swe_p = 0, esu_p = 0, ers_p = 0, ev_p = 0;
    logic [NBLK-1:0] cur_sel = '0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (ctl_swe && !swe_p) begin mark = cyc; pend = 1; end
            if (ctl_esu && !esu_p && pend) begin
                chk(cyc - mark == W_SWE_ON, "R3 setup wait before erase-setup", cyc - mark, W_SWE_ON);
                chk(blk_en == cur_sel, "R10 block enable matches choice", blk_en, cur_sel);
                pend = 0;
            end
            if (ctl_ers) begin
                if (!ers_p) pulses++;
                ew++;
            end else if (ers_p) begin
                chk(ew == W_ERASE, "R4 erase pulse width", ew, W_ERASE);
                ew = 0;
            end
            if (ctl_ev && !ev_p) exp_a = cur_base;
            if (wr) chk(wdata == 16'hFFFF && addr == 6'(exp_a), "R5 dummy write word", {wdata, 2'b0, addr}, {16'hFFFF, 2'b0, 6'(exp_a)});
            if (rd) begin
                chk(addr == 6'(exp_a), "R5 verify address", addr, exp_a);
                exp_a++;
            end
            if (done || fail || sel_err) begin
                int kind;
                kind = done ? 0 : (fail ? 1 : 2);
                if (q.size() == 0) chk(0, "R9 result without accepted start", kind, -1);
                else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(kind == e.kind, e.tag, kind, e.kind);
                    chk(pulses == e.pulses, "R7 erase pulse count", pulses, e.pulses);
                    if (kind != 2) chk(!ctl_swe, "R8 write-enable low at result", ctl_swe, 0);
                end
                pulses = 0;
                n_res++;
            end
        end
        swe_p = ctl_swe; esu_p = ctl_esu; ers_p = ctl_ers; ev_p = ctl_ev;
    end

    // Driver
    task automatic run_op(input logic [NBLK-1:0] sel, input int nd, input int stk_off,
                          input int lim, input bit poke, input string tag);
        int idx, nb, r0, le, kind, pul;
        bit oh;
        exp_t e;
        @(negedge clk);
        oh = ($countones(sel) == 1);
        idx = 0;
        for (int i = 0; i < NBLK; i++) if (sel[i]) idx = i;
        nb = (idx + 1) % NBLK;
        if (oh) begin
            for (int w = 0; w < BLKW; w++) mem[idx * BLKW + w] = 16'h0000;
            need[idx] = nd;
        end
        mem[nb * BLKW] = 16'h0000;
        need[nb] = 1;
        stuck_on = (stk_off >= 0);
        stuck_a  = idx * BLKW + stk_off;
        try_limit = TW'(lim);
        cur_base = idx * BLKW;
        cur_sel  = sel;
        le = (lim == 0) ? 1 : lim;
        if (!oh) begin kind = 2; pul = 0; end
        else if (stk_off >= 0) begin kind = 1; pul = le; end
        else begin
            pul = (nd < 1) ? 1 : nd;
            if (pul <= le) kind = 0;
            else begin kind = 1; pul = le; end
        end
        e.kind = kind; e.pulses = pul; e.tag = tag;
        q.push_back(e);
        r0 = n_res;
        blk_sel = sel; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            chk(busy, "R9 still busy at second start", busy, 1);
            blk_sel = sel ^ (sel << 1) ^ NBLK'(1); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (n_res == r0) @(negedge clk);
        @(negedge clk);
        chk(st_done == (kind == 0) && st_fail == (kind == 1), "R8 sticky outcome",
            {st_done, st_fail}, {kind == 0, kind == 1});
        chk(st_selerr == (kind == 2), "R2 sticky select error", st_selerr, kind == 2);
        chk(mem[nb * BLKW] == 16'h0000, "R10 other block untouched", mem[nb * BLKW], 0);
        repeat (2) @(negedge clk);
        chk(!busy && n_res == r0 + 1, "R9 one result per accepted start",
            {busy, 8'(n_res - r0)}, 1);
        if (kind == 2)
            chk({ctl_swe, ctl_esu, ctl_ers, ctl_ev, wdt_en} == 5'b0, "R2 no control raised",
                {ctl_swe, ctl_esu, ctl_ers, ctl_ev, wdt_en}, 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NW; i++) mem[i] = 16'h0000;
        for (int b = 0; b < NBLK; b++) need[b] = 0;
        repeat (3) @(negedge clk);
        chk({ctl_swe, ctl_esu, ctl_ers, ctl_ev, wdt_en, busy} == 6'b0 && blk_en == '0,
            "R1 outputs low in reset", {ctl_swe, ctl_esu, ctl_ers, ctl_ev, wdt_en, busy}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({done, fail, sel_err, st_done, st_fail, st_selerr, busy} == 7'b0,
            "R1 idle after reset", {done, fail, sel_err, st_done, st_fail, st_selerr, busy}, 0);

        run_op(8'b0000_0100, 1, -1, 3, 0, "R6 blank after one pulse");
        run_op(8'b0010_0000, 3, -1, 3, 0, "R7 pass on final retry");
        run_op(8'b0000_0001, 5, -1, 3, 0, "R7 fail at limit");
        run_op(8'b1000_0000, 1, BLKW - 1, 2, 0, "R6 miss on last word");
        run_op(8'b0000_0000, 1, -1, 3, 0, "R2 empty select");
        run_op(8'b0001_0100, 1, -1, 3, 0, "R2 two bits select");
        run_op(8'b0000_0010, 2, -1, 0, 0, "R7 zero limit acts as one");
        run_op(8'b0000_1000, 1, -1, 2, 1, "R9 start while busy");
        run_op(8'b0000_0010, 1, 0, 1, 0, "R6 miss on first word");
        run_op(8'b0100_0000, 0, -1, 1, 0, "R11 single pulse already blank");

        chk(q.size() == 0, "R9 no pending results", q.size(), 0);
        finish_run();
    end
endmodule